// File: doc/BRIEF.md
# Cascadable TDM Serial Audio Transmitter

This block turns one stereo pair of captured samples into a serial bit stream for a host, paced by an externally supplied bit clock and frame clock. Both clocks are oversampled by the system clock. The output changes once per bit period, on the active bit-clock edge. Four framings are available: I2S, left-justified, and DSP with the data starting either one slot after the frame pulse or in the same slot as the pulse. Word length and bit-clock polarity are selectable. In the two-channel framings, a polarity bit swaps which frame-clock level carries the left word.

In cascade mode several copies share one data line to the host. Each device sends its own left word and then its own right word. After that it relays the stream arriving on its chain input, delayed by exactly two words. The device nearest the host therefore emits L1 R1 L2 R2 L3 R3 L4 R4 in one frame, and the farthest device has its chain input tied low. Cascading gives a valid stream only with the DSP framings.

The control state machine has three states:
- `ST_WAIT` drives zero and waits for a frame start.
- `ST_ARM` is the one-slot gap before a delayed load. It keeps shifting the previous stream.
- `ST_SHIFT` streams the shift register.

The transitions are:
- **reserved → WAIT**: the reserved protocol code sends any state to `ST_WAIT` on the next active edge.
- **start-immediate → SHIFT**: a frame start in left-justified or DSP mode B loads and goes to `ST_SHIFT`.
- **start-delayed → ARM**: a frame start in I2S or DSP mode A goes to `ST_ARM`.
- **arm-expire → SHIFT**: `ST_ARM` loads on the next active edge and goes to `ST_SHIFT`.
- **hold**: otherwise the state is unchanged.

Top module: `tdm_cascade_tx`

## Requirements
- R1: After reset, `sdata` is 0 and stays 0 until the first frame start is seen.
- R2: DSP mode B (ctrl[1:0]=11, ctrl[5]=1): a frame starts at the active edge where `lrck` is first seen high. The left word is sent MSB first in that slot, and the right word follows in the next W slots.
- R3: DSP mode A (ctrl[1:0]=11, ctrl[5]=0): the same as R2, but every data bit comes one slot later.
- R4: Word length ctrl[4:2] sets W. The codes are 011=16, 010=18, 001=20, 000=24 and 100=32. Codes 101 to 111 act as 24. A W-bit word is taken from the top W bits of the 32-bit sample input.
- R5: I2S (ctrl[1:0]=00) sends the left word while `lrck` is low. Its MSB comes one slot after each `lrck` transition. Left-justified (01) sends the left word while `lrck` is high, with the MSB in the slot of the transition. Slots after the word are 0.
- R6: In I2S or left-justified framing, ctrl[5]=1 swaps the `lrck` level that carries the left word.
- R7: Cascade (ctrl[7]=1) in DSP framing: after its own 2W bits, the block outputs the `chain_in` stream delayed by exactly 2W slots. Four chained devices put L1 R1 L2 R2 L3 R3 L4 R4 on the line of the device nearest the host.
- R8: With ctrl[7]=0, the output is 0 after the block's own words, whatever arrives on `chain_in`.
- R9: Both samples are latched at the frame start (the left-half start in the two-channel framings). A change in mid-frame appears only in the next frame.
- R10: Protocol code 10 forces `sdata` to 0.
- R11: With ctrl[6]=0, `sdata` changes only after a falling `bclk` edge, and `lrck` is evaluated at that edge. With ctrl[6]=1, rising edges take that role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| lrck | input | 1 | Frame clock or frame pulse |
| chain_in | input | 1 | Serial stream from the next device down the chain |
| left_smp | input | MAX_W | Left sample, MSB aligned |
| right_smp | input | MAX_W | Right sample, MSB aligned |
| ctrl | input | 8 | Control: [7] cascade, [6] bit-clock invert, [5] polarity or DSP B, [4:2] word length, [1:0] protocol |
| sdata | output | 1 | Serial data to the host or to the next device up the chain |

## Verification
The hardest case to reach from the ports is a full four-device frame, because the third and fourth words only exist as bits relayed through two hops of 2W-slot delay. The bench places a second instance below the unit under test. It then drives that instance's chain input bit by bit, in step with the falling bit clock, as a third and fourth device would. This is done for both DSP modes, so the one-slot offset of mode A must line up across every hop. A mid-frame sample change is also forced at a fixed slot, to show that latching at the frame start prevents a torn word.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    typedef enum logic [1:0] {
        PROTO_I2S = 2'b00,
        PROTO_LJ  = 2'b01,
        PROTO_RSV = 2'b10,
        PROTO_DSP = 2'b11
    } proto_e;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_ARM   = 2'd1,
        ST_SHIFT = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic       casc;
        logic       bclk_inv;
        logic       pol;
        logic [2:0] wl;
        proto_e     proto;
    } ctrl_t;

    function automatic int word_bits(input logic [2:0] code);
        case (code)
            3'b001:  return 20;
            3'b010:  return 18;
            3'b011:  return 16;
            3'b100:  return 32;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/tdm_clk_edges.sv
module tdm_clk_edges #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic lrck,
    input  logic bclk_inv,
    output logic launch,
    output logic capture,
    output logic lrck_now
);
    logic [SYNC_STAGES-1:0] bsync;
    logic [SYNC_STAGES-1:0] lsync;
    logic                   bprev;
    logic                   eff_now;
    logic                   eff_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bsync <= '0;
            lsync <= '0;
            bprev <= 1'b0;
        end else begin
            bsync <= {bsync[SYNC_STAGES-2:0], bclk};
            lsync <= {lsync[SYNC_STAGES-2:0], lrck};
            bprev <= bsync[SYNC_STAGES-1];
        end
    end

    assign eff_now  = bsync[SYNC_STAGES-1] ^ bclk_inv;
    assign eff_prev = bprev ^ bclk_inv;
    assign launch   = eff_prev & ~eff_now;
    assign capture  = ~eff_prev & eff_now;
    assign lrck_now = lsync[SYNC_STAGES-1];

endmodule

// File: rtl/tdm_frame_fsm.sv
module tdm_frame_fsm
    import tdm_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   launch,
    input  logic   lrck_now,
    input  proto_e proto,
    input  logic   pol,
    output logic   load_now,
    output logic   shift_now,
    output logic   latch_now,
    output logic   sel_left,
    output logic   is_dsp,
    output logic   rsv
);
    tx_state_e state_q;
    tx_state_e state_d;
    logic      lrck_d;
    logic      start;
    logic      delayed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lrck_d <= 1'b0;
        else if (launch) lrck_d <= lrck_now;
    end

    assign is_dsp   = (proto == PROTO_DSP);
    assign rsv      = (proto == PROTO_RSV);
    assign start    = is_dsp ? (lrck_now & ~lrck_d) : (lrck_now ^ lrck_d);
    assign sel_left = ((proto == PROTO_LJ) ? lrck_now : ~lrck_now) ^ pol;
    assign delayed  = is_dsp ? ~pol : (proto == PROTO_I2S);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (launch) begin
            if (rsv)                   state_d = ST_WAIT;
            else if (start)            state_d = delayed ? ST_ARM : ST_SHIFT;
            else if (state_q == ST_ARM) state_d = ST_SHIFT;
        end
    end

    // outputs
    always_comb begin
        load_now  = 1'b0;
        shift_now = 1'b0;
        latch_now = launch & ~rsv & start & (is_dsp | sel_left);
        if (launch && !rsv) begin
            unique case (state_q)
                ST_WAIT: begin
                    load_now  = start & ~delayed;
                    shift_now = start & delayed;
                end
                ST_ARM: begin
                    load_now  = ~start | ~delayed;
                    shift_now = start & delayed;
                end
                ST_SHIFT: begin
                    load_now  = start & ~delayed;
                    shift_now = ~(start & ~delayed);
                end
                default: begin
                    load_now  = 1'b0;
                    shift_now = 1'b0;
                end
            endcase
        end
    end

    assert_arm_then_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && state_q == ST_ARM && !rsv && !start) |=> (state_q == ST_SHIFT));

    assert_rsv_to_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && rsv) |=> (state_q == ST_WAIT));

endmodule

// File: rtl/tdm_shift_path.sv
module tdm_shift_path
    import tdm_tx_pkg::*;
#(
    parameter int MAX_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             chain_in,
    input  logic             casc,
    input  logic [2:0]       wl_code,
    input  logic             latch_now,
    input  logic             load_now,
    input  logic             shift_now,
    input  logic             rsv,
    input  logic             is_dsp,
    input  logic             sel_left,
    input  logic [MAX_W-1:0] left_smp,
    input  logic [MAX_W-1:0] right_smp,
    output logic             sdata
);
    localparam int SR_W  = 2 * MAX_W;
    localparam int IDX_W = $clog2(SR_W);

    logic [MAX_W-1:0] hold_l, hold_r;
    logic [MAX_W-1:0] src_l, src_r, first_w, second_w, first_j, second_j;
    logic [SR_W-1:0]  sr, ld_vec;
    logic [IDX_W-1:0] w, rsh, tap, tap_m1;
    logic [IDX_W:0]   two_w;
    logic             chain_q;

    assign w      = IDX_W'(word_bits(wl_code));
    assign two_w  = {w, 1'b0};
    assign tap    = two_w[IDX_W-1:0] - IDX_W'(1);
    assign tap_m1 = tap - IDX_W'(1);
    assign rsh    = IDX_W'(MAX_W) - w;

    assign src_l    = latch_now ? left_smp  : hold_l;
    assign src_r    = latch_now ? right_smp : hold_r;
    assign first_w  = (is_dsp || sel_left) ? src_l : src_r;
    assign second_w = is_dsp ? src_r : '0;
    assign first_j  = first_w >> rsh;
    assign second_j = second_w >> rsh;
    assign ld_vec   = ({{MAX_W{1'b0}}, first_j} << w) | {{MAX_W{1'b0}}, second_j};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_l  <= '0;
            hold_r  <= '0;
            chain_q <= 1'b0;
            sr      <= '0;
            sdata   <= 1'b0;
        end else begin
            if (latch_now) begin
                hold_l <= left_smp;
                hold_r <= right_smp;
            end
            if (capture) chain_q <= casc & chain_in;
            if (load_now)       sr <= ld_vec;
            else if (shift_now) sr <= {sr[SR_W-2:0], chain_q};
            if (rsv)            sdata <= 1'b0;
            else if (load_now)  sdata <= ld_vec[tap];
            else if (shift_now) sdata <= sr[tap_m1];
        end
    end

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_now |=> ($stable(hold_l) && $stable(hold_r)));

    assert_no_load_and_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_now && shift_now));

endmodule

// File: rtl/tdm_cascade_tx.sv
module tdm_cascade_tx
    import tdm_tx_pkg::*;
#(
    parameter int MAX_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk,
    input  logic             lrck,
    input  logic             chain_in,
    input  logic [MAX_W-1:0] left_smp,
    input  logic [MAX_W-1:0] right_smp,
    input  logic [7:0]       ctrl,
    output logic             sdata
);
    ctrl_t cfg;
    logic  launch, capture, lrck_now;
    logic  load_now, shift_now, latch_now, sel_left, is_dsp, rsv;

    assign cfg = ctrl_t'(ctrl);

    tdm_clk_edges #(.SYNC_STAGES(SYNC_STAGES)) u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .lrck     (lrck),
        .bclk_inv (cfg.bclk_inv),
        .launch   (launch),
        .capture  (capture),
        .lrck_now (lrck_now)
    );

    tdm_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .lrck_now  (lrck_now),
        .proto     (cfg.proto),
        .pol       (cfg.pol),
        .load_now  (load_now),
        .shift_now (shift_now),
        .latch_now (latch_now),
        .sel_left  (sel_left),
        .is_dsp    (is_dsp),
        .rsv       (rsv)
    );

    tdm_shift_path #(.MAX_W(MAX_W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .chain_in  (chain_in),
        .casc      (cfg.casc),
        .wl_code   (cfg.wl),
        .latch_now (latch_now),
        .load_now  (load_now),
        .shift_now (shift_now),
        .rsv       (rsv),
        .is_dsp    (is_dsp),
        .sel_left  (sel_left),
        .left_smp  (left_smp),
        .right_smp (right_smp),
        .sdata     (sdata)
    );

    assert_rsv_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.proto == PROTO_RSV) |=> !sdata);

    assert_edge_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch && cfg.proto != PROTO_RSV) |=> $stable(sdata));

endmodule

// File: tb/tdm_cascade_tx_test.sv
`timescale 1ns/1ps
module tdm_cascade_tx_test;

    logic        clk = 1'b0;
    logic        rst_n, bclk, lrck, dn_chain;
    logic [7:0]  ctrl_u, ctrl_d;
    logic [31:0] lu, ru, ld, rd;
    logic        sd_u, sd_d;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    logic got   [256];
    logic exp_s [256];
    logic chn   [256];
    int   chg_slot = -1;
    logic [31:0] chg_l, chg_r;

    localparam logic [31:0] L1 = 32'hC3A5_5A3C, R1 = 32'h96F0_0F69;
    localparam logic [31:0] L2 = 32'hE817_4B2D, R2 = 32'h1F3C_A5B6;
    localparam logic [31:0] L3 = 32'hB4E1_7290, R3 = 32'h6D2B_C819;
    localparam logic [31:0] L4 = 32'hF05A_3C87, R4 = 32'h8B74_D2E5;

    always #4 clk = ~clk;

    tdm_cascade_tx uut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrck(lrck), .chain_in(sd_d),
        .left_smp(lu), .right_smp(ru), .ctrl(ctrl_u), .sdata(sd_u)
    );

    tdm_cascade_tx dn (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrck(lrck), .chain_in(dn_chain),
        .left_smp(ld), .right_smp(rd), .ctrl(ctrl_d), .sdata(sd_d)
    );

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic bit_slot(input logic lr, input logic ch, input logic inv, output logic s);
        @(posedge clk);
        bclk     <= inv;
        lrck     <= lr;
        dn_chain <= ch;
        repeat (4) @(posedge clk);
        @(negedge clk);
        s = sd_u;
        @(posedge clk);
        bclk <= ~inv;
        repeat (4) @(posedge clk);
    endtask

    task automatic run_frame(input int fl, input bit square, input logic inv);
        for (int k = 0; k < fl; k++) begin
            logic lr;
            logic s;
            lr = square ? (k >= fl / 2) : (k == 0);
            if (k == chg_slot) begin
                lu = chg_l;
                ru = chg_r;
            end
            bit_slot(lr, chn[k], inv, s);
            got[k] = s;
        end
    endtask

    task automatic clear_exp();
        for (int i = 0; i < 256; i++) begin
            exp_s[i] = 1'b0;
            chn[i]   = 1'b0;
        end
    endtask

    task automatic put_word(input int at, input logic [31:0] v, input int w, input bit to_chain);
        for (int i = 0; i < w; i++) begin
            if (to_chain) chn[at + i]   = v[31 - i];
            else          exp_s[at + i] = v[31 - i];
        end
    endtask

    task automatic compare(input string tag, input int fl);
        int bad;
        bad = -1;
        for (int k = 0; k < fl; k++)
            if (got[k] !== exp_s[k] && bad < 0) bad = k;
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s slot %0d: got %b expected %b", tag, bad, got[bad], exp_s[bad]);
        end
    endtask

    // R1: output quiet after reset and before any frame start
    task automatic test_reset();
        logic s;
        int   bad;
        checks++;
        if (sd_u !== 1'b0) begin
            fails++;
            $display("FAIL R1 after reset: got %b expected 0", sd_u);
        end
        ctrl_u = 8'b0_0_1_011_11;
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            bit_slot(1'b0, 1'b0, 1'b0, s);
            if (s !== 1'b0) bad++;
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL R1 no frame start: got %0d nonzero slots expected 0", bad);
        end
    endtask

    // R2, R4: DSP mode B across all word length codes
    task automatic test_wordlen(input logic [2:0] code, input int w);
        ctrl_u = {3'b001, code, 2'b11};
        lu = L1; ru = R1;
        clear_exp();
        put_word(0, L1, w, 1'b0);
        put_word(w, R1, w, 1'b0);
        run_frame(80, 1'b0, 1'b0);
        run_frame(80, 1'b0, 1'b0);
        compare($sformatf("R4 R2 wl=%0d", w), 80);
    endtask

    // R3: DSP mode A, one slot later
    task automatic test_dspa();
        ctrl_u = 8'b0_0_0_011_11;
        lu = L1; ru = R1;
        clear_exp();
        put_word(1, L1, 16, 1'b0);
        put_word(17, R1, 16, 1'b0);
        run_frame(48, 1'b0, 1'b0);
        run_frame(48, 1'b0, 1'b0);
        compare("R3 dsp mode A", 48);
    endtask

    // R5, R6: two-channel framings
    task automatic test_twoch(input logic [7:0] c, input int w, input logic [31:0] first,
                              input int off, input logic [31:0] second, input string tag);
        ctrl_u = c;
        lu = L1; ru = R1;
        clear_exp();
        put_word(off, first, w, 1'b0);
        put_word(32 + off, second, w, 1'b0);
        run_frame(64, 1'b1, 1'b0);
        run_frame(64, 1'b1, 1'b0);
        compare(tag, 64);
    endtask

    // R7: four-device chain, R8: cascade off ignores chain
    task automatic test_chain(input logic pol, input logic casc_u, input string tag);
        int off;
        off = pol ? 0 : 1;
        ctrl_u = {casc_u, 1'b0, pol, 3'b011, 2'b11};
        ctrl_d = {1'b1,   1'b0, pol, 3'b011, 2'b11};
        lu = L1; ru = R1; ld = L2; rd = R2;
        clear_exp();
        put_word(off,      L3, 16, 1'b1);
        put_word(off + 16, R3, 16, 1'b1);
        put_word(off + 32, L4, 16, 1'b1);
        put_word(off + 48, R4, 16, 1'b1);
        put_word(off,      L1, 16, 1'b0);
        put_word(off + 16, R1, 16, 1'b0);
        if (casc_u) begin
            put_word(off + 32,  L2, 16, 1'b0);
            put_word(off + 48,  R2, 16, 1'b0);
            put_word(off + 64,  L3, 16, 1'b0);
            put_word(off + 80,  R3, 16, 1'b0);
            put_word(off + 96,  L4, 16, 1'b0);
            put_word(off + 112, R4, 16, 1'b0);
        end
        run_frame(136, 1'b0, 1'b0);
        run_frame(136, 1'b0, 1'b0);
        compare(tag, 136);
    endtask

    // R9: mid-frame sample update does not tear the word
    task automatic test_latch();
        ctrl_u = 8'b0_0_1_011_11;
        lu = L1; ru = R1;
        clear_exp();
        run_frame(48, 1'b0, 1'b0);
        put_word(0, L1, 16, 1'b0);
        put_word(16, R1, 16, 1'b0);
        chg_l = L4; chg_r = R4; chg_slot = 4;
        run_frame(48, 1'b0, 1'b0);
        chg_slot = -1;
        compare("R9 mid-frame change held off", 48);
        clear_exp();
        put_word(0, L4, 16, 1'b0);
        put_word(16, R4, 16, 1'b0);
        run_frame(48, 1'b0, 1'b0);
        compare("R9 new words next frame", 48);
    endtask

    // R10: reserved protocol silences output
    task automatic test_reserved();
        ctrl_u = 8'b0_0_1_011_10;
        lu = L1; ru = R1;
        clear_exp();
        run_frame(48, 1'b0, 1'b0);
        run_frame(48, 1'b0, 1'b0);
        compare("R10 reserved protocol", 48);
    endtask

    // R11: inverted bit clock with matching physical clock
    task automatic test_inv();
        ctrl_u = 8'b0_1_1_011_11;
        lu = L2; ru = R2;
        clear_exp();
        put_word(0, L2, 16, 1'b0);
        put_word(16, R2, 16, 1'b0);
        run_frame(48, 1'b0, 1'b1);
        run_frame(48, 1'b0, 1'b1);
        compare("R11 inverted bit clock", 48);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        rst_n = 1'b0; bclk = 1'b0; lrck = 1'b0; dn_chain = 1'b0;
        ctrl_u = 8'h00; ctrl_d = 8'h00;
        lu = '0; ru = '0; ld = '0; rd = '0;
        chg_l = '0; chg_r = '0;
        clear_exp();
        repeat (5) @(posedge clk);
        rst_n <= 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        test_reset();
        test_wordlen(3'b011, 16);
        test_wordlen(3'b010, 18);
        test_wordlen(3'b001, 20);
        test_wordlen(3'b000, 24);
        test_wordlen(3'b100, 32);
        test_dspa();
        test_twoch(8'b0_0_0_000_00, 24, L1, 1, R1, "R5 I2S left low");
        test_twoch(8'b0_0_0_011_01, 16, R1, 0, L1, "R5 LJ left high");
        test_twoch(8'b0_0_1_011_00, 16, R1, 1, L1, "R6 I2S swapped");
        test_chain(1'b1, 1'b1, "R7 four-device chain mode B");
        test_chain(1'b0, 1'b1, "R7 four-device chain mode A");
        test_chain(1'b1, 1'b0, "R8 cascade off ignores chain");
        test_latch();
        test_reserved();
        test_inv();
        finish_up();
    end

endmodule